// File: doc/BRIEF.md
# Power-On Strap Sampler

This block reads configuration straps from pads that are shared between a strap input and a clock output. When power-good rises, a timer counts a fixed window of reference-clock cycles. Throughout that window every shared pad keeps its output buffer disabled, so an external pull resistor alone sets the pad level. At the terminal cycle of the window, the synchronized level of each pad is captured. From the next cycle on, every pad's output enable is asserted and the pad carries its clock.

The captured bits stay fixed for as long as power-good stays high. No pad activity changes them, and the block has no other clear path. Dropping power-good clears them, and the next rise of power-good starts a fresh window. Two decoded views of the straps are provided. Strap 0 chooses the rate of a secondary clock output. Strap 1 is frequency-select bit 1 for the main synthesizer.

Top module: `strap_sampler`

## Requirements
- R1: From the release of power-good until the window ends, every `pad_oe` bit is 0 and `straps_valid` is 0.
- R2: With power-good released between clock edges, `pad_oe` and `straps_valid` are still 0 after edge WINDOW_CYCLES-1. They are 1 after rising edge WINDOW_CYCLES, and no second window follows.
- R3: Each captured bit records its own pad's level. A low pad stores 0 and a high pad stores 1, independently per pad.
- R4: `pad_oe` is never nonzero while `straps_valid` is 0. All enables, `straps_valid` and the captured bits become valid on the same edge.
- R5: Once captured, `strap_bits` does not change for any later pad activity while power-good stays high.
- R6: A low `pwr_good` clears `strap_bits`, `pad_oe` and `straps_valid` at once, without waiting for a clock edge. Its next rise starts a new window that samples the pads again.
- R7: `sec_clk_24m` equals strap 0: 1 selects 24 MHz and 0 selects 48 MHz. `fsel1` equals strap 1.
- R8: Each pad passes through SYNC_STAGES flops before capture. With the default of 2, the captured value is the pad level present at rising edge WINDOW_CYCLES-2. A change after that edge is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | Supply-valid indication; low clears everything asynchronously |
| pad_in | input | N_PADS | Level seen on each shared pad |
| pad_oe | output | N_PADS | Output-buffer enable for each shared pad |
| strap_bits | output | N_PADS | Captured strap values |
| straps_valid | output | 1 | High once straps are captured, until power-good drops |
| sec_clk_24m | output | 1 | Secondary clock rate select (1 = 24 MHz, 0 = 48 MHz) |
| fsel1 | output | 1 | Frequency-select bit 1 taken from strap 1 |

## Verification
Each pad combination (00, 01, 10, 11) is loaded across power cycles. This shows that every bit is captured from its own pad and decoded to the right output, and that power cycling really resamples the pads. Outputs are sampled one edge before and exactly at the terminal edge, which exposes an off-by-one in the window length. One run raises one pad just before the last edge that the synchronizer still catches, and raises the other pad just after that edge. This separates a correct two-stage capture from a shorter or longer path. Pads toggled after capture show whether the straps are truly held.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic {
    PH_WINDOW = 1'b0,
    PH_DRIVE  = 1'b1
  } phase_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic at_terminal(input int unsigned count,
                                       input int unsigned limit);
    return (count == limit - 1);
  endfunction

endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk_ref,
  input  logic pwr_good,
  output logic window_done,
  output logic window_open
);
  localparam int unsigned CW = cnt_width(WINDOW_CYCLES);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  assign window_open = (phase_q == PH_WINDOW);
  assign window_done = window_open && at_terminal(32'(cnt_q), WINDOW_CYCLES);

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      phase_q <= PH_WINDOW;
      cnt_q   <= '0;
    end else if (window_open) begin
      if (window_done) phase_q <= PH_DRIVE;
      else             cnt_q   <= cnt_q + CW'(1);
    end
  end

  p_cnt_frozen_r2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !window_open |=> $stable(cnt_q));
  p_drive_sticky_r2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !window_open |=> !window_open);
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned N_PADS      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              pwr_good,
  input  logic [N_PADS-1:0] pad_in,
  output logic [N_PADS-1:0] pad_sync
);
  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_ref or negedge pwr_good) begin
      if (!pwr_good) chain_q <= '0;
      else if (SYNC_STAGES == 1) chain_q <= pad_in[p];
      else chain_q <= {chain_q[SYNC_STAGES-2:0], pad_in[p]};
    end
    assign pad_sync[p] = chain_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned N_PADS = 2
) (
  input  logic              clk_ref,
  input  logic              pwr_good,
  input  logic              window_done,
  input  logic [N_PADS-1:0] pad_sync,
  output logic [N_PADS-1:0] strap_q,
  output logic              captured
);
  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      strap_q  <= '0;
      captured <= 1'b0;
    end else if (window_done && !captured) begin
      strap_q  <= pad_sync;
      captured <= 1'b1;
    end
  end

  p_hold_r5: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    captured |=> $stable(strap_q) && captured);
  p_done_before_latch_r2: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    window_done |-> !captured);
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int unsigned N_PADS        = 2,
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_ref,
  input  logic              pwr_good,
  input  logic [N_PADS-1:0] pad_in,
  output logic [N_PADS-1:0] pad_oe,
  output logic [N_PADS-1:0] strap_bits,
  output logic              straps_valid,
  output logic              sec_clk_24m,
  output logic              fsel1
);
  logic              window_done;
  logic              window_open;
  logic [N_PADS-1:0] pad_sync;
  logic              captured;
  logic [N_PADS-1:0] oe_q;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_ref(clk_ref), .pwr_good(pwr_good),
    .window_done(window_done), .window_open(window_open)
  );

  strap_sync #(.N_PADS(N_PADS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_ref(clk_ref), .pwr_good(pwr_good),
    .pad_in(pad_in), .pad_sync(pad_sync)
  );

  strap_capture #(.N_PADS(N_PADS)) u_cap (
    .clk_ref(clk_ref), .pwr_good(pwr_good), .window_done(window_done),
    .pad_sync(pad_sync), .strap_q(strap_bits), .captured(captured)
  );

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good)        oe_q <= '0;
    else if (window_done) oe_q <= '1;
  end

  assign pad_oe       = oe_q;
  assign straps_valid = captured;
  assign sec_clk_24m  = strap_bits[0];
  assign fsel1        = strap_bits[1];

  p_tristate_r1: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    window_open |-> (pad_oe == '0) && !straps_valid);
  p_oe_with_latch_r4: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (pad_oe != '0) |-> captured);
  p_latch_with_oe_r4: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    captured |-> (pad_oe == '1));
endmodule

// File: tb/sim_strap_sampler.sv
module sim_strap_sampler;
  localparam int unsigned W = 64;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic [1:0] pads = 2'b00;
  logic [1:0] pad_oe, strap_bits;
  logic       straps_valid, sec_clk_24m, fsel1;
  int         n_run = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  strap_sampler #(.N_PADS(2), .WINDOW_CYCLES(W), .SYNC_STAGES(2)) u0 (
    .clk_ref(clk), .pwr_good(pwr_good), .pad_in(pads), .pad_oe(pad_oe),
    .strap_bits(strap_bits), .straps_valid(straps_valid),
    .sec_clk_24m(sec_clk_24m), .fsel1(fsel1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_off;
    @(negedge clk);
    pwr_good = 1'b0;
    #1;
    chk("R6 oe cleared", 32'(pad_oe), 0);
    chk("R6 straps cleared", 32'(strap_bits), 0);
    chk("R6 valid cleared", 32'(straps_valid), 0);
  endtask

  // full window with a fixed pad pattern
  task automatic t_window(input logic [1:0] pat);
    power_off();
    pads = pat;
    @(negedge clk);
    pwr_good = 1'b1;
    edges(W / 2);
    chk("R1 oe mid-window", 32'(pad_oe), 0);
    chk("R1 valid mid-window", 32'(straps_valid), 0);
    edges(W / 2 - 1);
    chk("R2 oe at W-1", 32'(pad_oe), 0);
    chk("R4 valid at W-1", 32'(straps_valid), 0);
    edges(1);
    chk("R2 oe at W", 32'(pad_oe), 32'h3);
    chk("R4 valid with oe", 32'(straps_valid), 1);
    chk("R3 captured bits", 32'(strap_bits), 32'(pat));
    chk("R7 sec clock select", 32'(sec_clk_24m), 32'(pat[0]));
    chk("R7 fsel1", 32'(fsel1), 32'(pat[1]));
  endtask

  task automatic t_hold(input logic [1:0] expect_bits);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pads = 2'(i);
    end
    edges(4);
    chk("R5 straps held", 32'(strap_bits), 32'(expect_bits));
    chk("R2 oe still on", 32'(pad_oe), 32'h3);
  endtask

  task automatic t_sync_edge;
    power_off();
    pads = 2'b00;
    @(negedge clk);
    pwr_good = 1'b1;
    edges(W - 3);
    @(negedge clk);
    pads[0] = 1'b1;
    edges(1);
    @(negedge clk);
    pads[1] = 1'b1;
    edges(2);
    chk("R8 sync capture point", 32'(strap_bits), 32'h1);
    chk("R8 valid", 32'(straps_valid), 1);
  endtask

  initial begin
    #3;
    chk("R6 reset oe", 32'(pad_oe), 0);
    chk("R6 reset straps", 32'(strap_bits), 0);
    chk("R6 reset valid", 32'(straps_valid), 0);
    t_window(2'b01);
    t_hold(2'b01);
    t_window(2'b10);
    t_window(2'b11);
    t_hold(2'b11);
    t_window(2'b00);
    t_sync_edge();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule